// File: doc/BRIEF.md
# Shared Frame Anchor and Alias Tracker

This block keeps the mapping state for physical frames that can be mapped by several virtual pages at once. Each frame has exactly one anchor entry. The anchor is the only place that frame's metadata lives: a sharer count, a lock bit and a dirty bit. Each virtual mapping is a light alias record. An alias is found by hashing its (process id, virtual page) key into a bucket of chained records, and it carries nothing about the frame except a pointer to the anchor.

Every anchor also heads a doubly linked list of its aliases. An operation on a whole frame can therefore start at the anchor and reach every sharer. An invalidate-frame command walks that list and streams one shootdown event per alias, so that a downstream agent can tell each sharer to drop its cached translation. A move command performs a copy-on-write split. It detaches one alias from its frame and attaches it to a new frame, and the other sharers stay where they are. When a frame's last alias leaves, the block emits a free-frame pulse.

Commands enter one at a time through a valid/ready pair. Each command ends with a single response pulse.

Top module: `frame_alias_tracker`

## Requirements
- R1: After reset, cmd_ready is high and rsp_valid, ev_valid and free_valid are low. Every frame reads count 0, unlocked and clean, and every lookup misses.
- R2: MAP (cmd_op 0) creates an alias for (cmd_pid, cmd_vpn) pointing at cmd_frame. It raises that frame's count by one, sets the dirty bit when cmd_dirty is 1, and places the new alias at the head of the frame's sharer list.
- R3: MAP is refused with rsp_err = 1 and leaves all state unchanged in two cases: when the key is already mapped (rsp_hit = 1), or when all 64 alias slots are in use (rsp_hit = 0). After a slot is released, a MAP succeeds again.
- R4: LOOKUP (cmd_op 2) never errs. On a hit it returns rsp_hit = 1, the frame, and that frame's count, lock and dirty bits. On a miss it returns rsp_hit = 0. The key's bucket is the XOR of the successive 4-bit slices of {pid, vpn}, starting at the least significant bit of vpn. Keys that share a bucket are all resolved correctly.
- R5: UNMAP (cmd_op 1) removes the alias, lowers its frame's count by one and frees the slot. This also holds when the alias sits in the middle of a sharer list or a bucket chain. An unknown key gives rsp_err = 1.
- R6: When a frame's count drops to zero, free_valid pulses with free_frame equal to that frame in the same cycle as the response, and the frame's dirty bit is cleared.
- R7: INVALIDATE (cmd_op 3) emits one ev_valid cycle per alias of cmd_frame. The events come in consecutive cycles, most recently linked alias first. In the cycle after the last event, rsp_valid and inv_done pulse together. A frame with no aliases gives the response with no events. The aliases stay mapped.
- R8: LOCK (cmd_op 4) and UNLOCK (cmd_op 5) set and clear a frame's lock bit. While the bit is set, the frame's count and aliases cannot change: MAP into it, UNMAP of its alias, INVALIDATE of it, and MOVE from or to it all give rsp_err = 1, and INVALIDATE emits no events. LOOKUP and QUERY are still served.
- R9: MOVE (cmd_op 6) relinks an existing alias from its frame to cmd_frame. The old frame's count drops by one. The new frame's count rises by one and its dirty bit is set. The remaining sharers of the old frame are untouched. An unknown key, or a cmd_frame equal to the current frame, gives rsp_err = 1.
- R10: QUERY (cmd_op 7) returns cmd_frame's count, lock and dirty bits with rsp_err = 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 3 | Operation code |
| cmd_pid | input | 8 | Process id of the alias key |
| cmd_vpn | input | 20 | Virtual page number of the alias key |
| cmd_frame | input | 5 | Target frame |
| cmd_dirty | input | 1 | MAP marks the frame dirty |
| rsp_valid | output | 1 | Response pulse, one per command |
| rsp_err | output | 1 | Command refused |
| rsp_hit | output | 1 | Key was found |
| rsp_frame | output | 5 | Frame the response refers to |
| rsp_count | output | 7 | Sharer count (LOOKUP hit, QUERY) |
| rsp_lock | output | 1 | Lock bit (LOOKUP hit, QUERY) |
| rsp_dirty | output | 1 | Dirty bit (LOOKUP hit, QUERY) |
| ev_valid | output | 1 | Shootdown event present |
| ev_pid | output | 8 | Process id of the sharer to invalidate |
| ev_vpn | output | 20 | Virtual page of the sharer to invalidate |
| inv_done | output | 1 | Invalidate walk finished |
| free_valid | output | 1 | A frame lost its last sharer |
| free_frame | output | 5 | The frame that became free |

## Verification
The hardest state to reach is slot exhaustion while the lists are already irregular. Earlier scenarios leave aliases behind that were unlinked from mid-list and mid-chain positions and moved between frames. The bench then fills every remaining slot with keys that spread over many buckets, so the full check runs on pointers made crooked by earlier operations. Bucket collisions are created on purpose by flipping key bit pairs that fold onto the same bucket bit, and the bench's own fold confirms them. A middle record of that chain is then removed.

// File: rtl/fat_pkg.sv
package fat_pkg;
  localparam int unsigned NFRAMES = 32;
  localparam int unsigned NALIAS  = 64;
  localparam int unsigned NBUCKET = 16;
  localparam int unsigned PID_W   = 8;
  localparam int unsigned VPN_W   = 20;
  localparam int unsigned FW      = $clog2(NFRAMES);
  localparam int unsigned AW      = $clog2(NALIAS);
  localparam int unsigned PW      = $clog2(NALIAS + 1);
  localparam int unsigned BW      = $clog2(NBUCKET);
  localparam int unsigned KEY_W   = PID_W + VPN_W;

  typedef logic [PW-1:0] ptr_t;
  typedef logic [FW-1:0] frame_t;
  typedef logic [BW-1:0] bkt_t;

  // pointer value meaning "no record"
  localparam ptr_t NIL = ptr_t'(NALIAS);

  typedef struct packed {
    ptr_t cnt;
    logic lock;
    logic dirty;
    ptr_t head;
  } anchor_t;

  typedef struct packed {
    logic   err;
    logic   hit;
    frame_t frame;
    ptr_t   cnt;
    logic   lock;
    logic   dirty;
  } rsp_t;

  typedef enum logic [2:0] {
    OP_MAP = 3'd0, OP_UNMAP = 3'd1, OP_LOOKUP = 3'd2, OP_INVAL = 3'd3,
    OP_LOCK = 3'd4, OP_UNLOCK = 3'd5, OP_MOVE = 3'd6, OP_QUERY = 3'd7
  } op_e;

  // bit i of the key folds onto bucket bit (i mod BW)
  function automatic bkt_t bucket_of(input logic [PID_W-1:0] pid,
                                     input logic [VPN_W-1:0] vpn);
    logic [KEY_W-1:0] k;
    bkt_t b;
    k = {pid, vpn};
    b = '0;
    for (int i = 0; i < KEY_W; i++) b[i % BW] = b[i % BW] ^ k[i];
    return b;
  endfunction

  function automatic rsp_t mk_rsp(input logic err, input logic hit, input frame_t fr,
                                  input ptr_t cnt, input logic lock, input logic dirty);
    rsp_t r;
    r.err = err; r.hit = hit; r.frame = fr;
    r.cnt = cnt; r.lock = lock; r.dirty = dirty;
    return r;
  endfunction
endpackage

// File: rtl/fat_slot_pool.sv
module fat_slot_pool #(
  parameter int unsigned NSLOT = 64,
  localparam int unsigned SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          release_en,
  input  logic [SW-1:0] release_idx,
  output logic [SW-1:0] alloc_idx,
  output logic          empty
);
  logic [NSLOT-1:0] free_q;

  // lowest free slot wins
  always_comb begin
    alloc_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (free_q[i]) alloc_idx = SW'(i);
  end

  assign empty = ~|free_q;

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else begin
      if (alloc_en)   free_q[alloc_idx]   <= 1'b0;
      if (release_en) free_q[release_idx] <= 1'b1;
    end
  end

  // R3
  alloc_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !empty);
  // R5
  release_of_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_en |-> !free_q[release_idx]);
endmodule

// File: rtl/fat_anchor_table.sv
module fat_anchor_table
  import fat_pkg::*;
#(
  parameter int unsigned NF = NFRAMES
) (
  input  logic    clk,
  input  logic    rst_n,
  input  frame_t  rd_a_idx,
  output anchor_t rd_a,
  input  frame_t  rd_b_idx,
  output anchor_t rd_b,
  input  logic    wa_en,
  input  frame_t  wa_idx,
  input  anchor_t wa_data,
  input  logic    wb_en,
  input  frame_t  wb_idx,
  input  anchor_t wb_data,
  output logic    free_valid,
  output frame_t  free_frame
);
  anchor_t tab [NF];

  assign rd_a = tab[rd_a_idx];
  assign rd_b = tab[rd_b_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) tab[i] <= '{cnt: '0, lock: 1'b0, dirty: 1'b0, head: NIL};
      free_valid <= 1'b0;
      free_frame <= '0;
    end else begin
      if (wa_en) tab[wa_idx] <= wa_data;
      if (wb_en) tab[wb_idx] <= wb_data;
      free_valid <= wa_en && (wa_data.cnt == '0) && (tab[wa_idx].cnt != '0);
      free_frame <= wa_idx;
    end
  end

  // port A only ever releases one sharer: R5
  release_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |-> (wa_data.cnt + ptr_t'(1) == tab[wa_idx].cnt));
  // port B adds at most one sharer: R2
  attach_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data.cnt == tab[wb_idx].cnt || wb_data.cnt == tab[wb_idx].cnt + ptr_t'(1)));
  // R8
  locked_frame_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && tab[wb_idx].lock) |-> (wb_data.cnt == tab[wb_idx].cnt && wb_data.head == tab[wb_idx].head));
  // R8
  locked_no_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |-> !tab[wa_idx].lock);
  // R6
  free_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> (tab[free_frame].cnt == '0 && !tab[free_frame].dirty));
  // R9
  ports_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_idx != wb_idx));
endmodule

// File: rtl/frame_alias_tracker.sv
module frame_alias_tracker
  import fat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [PID_W-1:0] cmd_pid,
  input  logic [VPN_W-1:0] cmd_vpn,
  input  logic [FW-1:0]    cmd_frame,
  input  logic             cmd_dirty,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             rsp_hit,
  output logic [FW-1:0]    rsp_frame,
  output logic [PW-1:0]    rsp_count,
  output logic             rsp_lock,
  output logic             rsp_dirty,
  output logic             ev_valid,
  output logic [PID_W-1:0] ev_pid,
  output logic [VPN_W-1:0] ev_vpn,
  output logic             inv_done,
  output logic             free_valid,
  output logic [FW-1:0]    free_frame
);
  typedef enum logic [1:0] {S_IDLE, S_WALK, S_EXEC, S_INVAL} state_e;
  state_e state;

  // alias records, one field per array
  logic [PID_W-1:0] r_pid   [NALIAS];
  logic [VPN_W-1:0] r_vpn   [NALIAS];
  frame_t           r_frame [NALIAS];
  ptr_t             r_hprev [NALIAS];
  ptr_t             r_hnext [NALIAS];
  ptr_t             r_fprev [NALIAS];
  ptr_t             r_fnext [NALIAS];
  ptr_t             bh      [NBUCKET];

  op_e              q_op;
  logic [PID_W-1:0] q_pid;
  logic [VPN_W-1:0] q_vpn;
  frame_t           q_frame;
  logic             q_dirty;
  bkt_t             q_bkt;
  ptr_t             cur, hidx;
  logic             hit;
  rsp_t             rsp_q;

  // named internal events
  logic    accept, walk_match, do_map, do_unmap, do_move, unlink, exec_err;
  op_e     c_op;
  bkt_t    c_bkt;
  logic [AW-1:0] hs, cs, alloc_idx;
  logic    pool_empty;
  frame_t  old_frame, rd_b_idx;
  anchor_t ha, tb, wa_data, wb_data;
  logic    wa_en, wb_en;
  ptr_t    n_ptr, bhd, th, fp, fn, hp, hn;

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign c_op      = op_e'(cmd_op);
  assign c_bkt     = bucket_of(cmd_pid, cmd_vpn);
  assign hs        = hidx[AW-1:0];
  assign cs        = cur[AW-1:0];
  assign old_frame = r_frame[hs];
  assign rd_b_idx  = (state == S_IDLE) ? cmd_frame : q_frame;
  assign walk_match = (cur != NIL) && (r_pid[cs] == q_pid) && (r_vpn[cs] == q_vpn);
  assign n_ptr = ptr_t'(alloc_idx);
  assign bhd = bh[q_bkt];
  assign th  = tb.head;
  assign fp  = r_fprev[hs];
  assign fn  = r_fnext[hs];
  assign hp  = r_hprev[hs];
  assign hn  = r_hnext[hs];

  always_comb begin
    do_map   = 1'b0;
    do_unmap = 1'b0;
    do_move  = 1'b0;
    exec_err = 1'b0;
    case (q_op)
      OP_MAP:   exec_err = hit || pool_empty || tb.lock;
      OP_UNMAP: exec_err = !hit || ha.lock;
      OP_MOVE:  exec_err = !hit || ha.lock || tb.lock || (old_frame == q_frame);
      default:  exec_err = 1'b0;
    endcase
    if (state == S_EXEC && !exec_err) begin
      do_map   = (q_op == OP_MAP);
      do_unmap = (q_op == OP_UNMAP);
      do_move  = (q_op == OP_MOVE);
    end
    unlink = do_unmap || do_move;

    // port A: the frame an alias leaves
    wa_en         = unlink;
    wa_data.cnt   = ha.cnt - ptr_t'(1);
    wa_data.lock  = ha.lock;
    wa_data.dirty = (ha.cnt == ptr_t'(1)) ? 1'b0 : ha.dirty;
    wa_data.head  = (fp == NIL) ? fn : ha.head;

    // port B: the frame an alias joins, or a lock change
    wb_en   = 1'b0;
    wb_data = tb;
    if (accept && (c_op == OP_LOCK || c_op == OP_UNLOCK)) begin
      wb_en        = 1'b1;
      wb_data.lock = (c_op == OP_LOCK);
    end else if (do_map || do_move) begin
      wb_en         = 1'b1;
      wb_data.cnt   = tb.cnt + ptr_t'(1);
      wb_data.dirty = do_move ? 1'b1 : (tb.dirty | q_dirty);
      wb_data.head  = do_move ? hidx : n_ptr;
    end
  end

  fat_anchor_table #(.NF(NFRAMES)) u_anchor (
    .clk, .rst_n,
    .rd_a_idx(old_frame), .rd_a(ha),
    .rd_b_idx(rd_b_idx),  .rd_b(tb),
    .wa_en, .wa_idx(old_frame), .wa_data,
    .wb_en, .wb_idx(rd_b_idx),  .wb_data,
    .free_valid, .free_frame
  );

  fat_slot_pool #(.NSLOT(NALIAS)) u_pool (
    .clk, .rst_n,
    .alloc_en(do_map), .release_en(do_unmap), .release_idx(hs),
    .alloc_idx, .empty(pool_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      for (int i = 0; i < NBUCKET; i++) bh[i] <= NIL;
      for (int i = 0; i < NALIAS; i++) begin
        r_pid[i] <= '0; r_vpn[i] <= '0; r_frame[i] <= '0;
        r_hprev[i] <= NIL; r_hnext[i] <= NIL; r_fprev[i] <= NIL; r_fnext[i] <= NIL;
      end
      q_op <= OP_MAP; q_pid <= '0; q_vpn <= '0; q_frame <= '0; q_dirty <= 1'b0; q_bkt <= '0;
      cur <= NIL; hidx <= NIL; hit <= 1'b0;
      rsp_q <= '0; rsp_valid <= 1'b0; inv_done <= 1'b0;
      ev_valid <= 1'b0; ev_pid <= '0; ev_vpn <= '0;
    end else begin
      rsp_valid <= 1'b0;
      inv_done  <= 1'b0;
      ev_valid  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          q_op <= c_op; q_pid <= cmd_pid; q_vpn <= cmd_vpn;
          q_frame <= cmd_frame; q_dirty <= cmd_dirty; q_bkt <= c_bkt;
          case (c_op)
            OP_MAP, OP_UNMAP, OP_LOOKUP, OP_MOVE: begin
              cur   <= bh[c_bkt];
              state <= S_WALK;
            end
            OP_INVAL: if (tb.lock) begin
              rsp_q <= mk_rsp(1'b1, 1'b0, cmd_frame, '0, 1'b0, 1'b0);
              rsp_valid <= 1'b1;
            end else begin
              cur   <= tb.head;
              state <= S_INVAL;
            end
            OP_QUERY: begin
              rsp_q <= mk_rsp(1'b0, 1'b0, cmd_frame, tb.cnt, tb.lock, tb.dirty);
              rsp_valid <= 1'b1;
            end
            default: begin
              rsp_q <= mk_rsp(1'b0, 1'b0, cmd_frame, '0, 1'b0, 1'b0);
              rsp_valid <= 1'b1;
            end
          endcase
        end
        S_WALK: begin
          if (cur == NIL || walk_match) begin
            hit   <= walk_match;
            hidx  <= walk_match ? cur : NIL;
            state <= S_EXEC;
          end else begin
            cur <= r_hnext[cs];
          end
        end
        S_EXEC: begin
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
          if (q_op == OP_LOOKUP)
            rsp_q <= hit ? mk_rsp(1'b0, 1'b1, old_frame, ha.cnt, ha.lock, ha.dirty)
                         : mk_rsp(1'b0, 1'b0, q_frame, '0, 1'b0, 1'b0);
          else
            rsp_q <= mk_rsp(exec_err, hit, (q_op == OP_UNMAP && hit) ? old_frame : q_frame,
                            '0, 1'b0, 1'b0);
          if (do_map) begin
            r_pid[alloc_idx]   <= q_pid;
            r_vpn[alloc_idx]   <= q_vpn;
            r_frame[alloc_idx] <= q_frame;
            r_hprev[alloc_idx] <= NIL;
            r_hnext[alloc_idx] <= bhd;
            if (bhd != NIL) r_hprev[bhd[AW-1:0]] <= n_ptr;
            bh[q_bkt] <= n_ptr;
            r_fprev[alloc_idx] <= NIL;
            r_fnext[alloc_idx] <= th;
            if (th != NIL) r_fprev[th[AW-1:0]] <= n_ptr;
          end
          if (unlink) begin
            if (fp != NIL) r_fnext[fp[AW-1:0]] <= fn;
            if (fn != NIL) r_fprev[fn[AW-1:0]] <= fp;
          end
          if (do_unmap) begin
            if (hp == NIL) bh[q_bkt] <= hn;
            else           r_hnext[hp[AW-1:0]] <= hn;
            if (hn != NIL) r_hprev[hn[AW-1:0]] <= hp;
          end
          if (do_move) begin
            r_frame[hs] <= q_frame;
            r_fprev[hs] <= NIL;
            r_fnext[hs] <= th;
            if (th != NIL) r_fprev[th[AW-1:0]] <= hidx;
          end
        end
        S_INVAL: begin
          if (cur == NIL) begin
            rsp_q     <= mk_rsp(1'b0, 1'b0, q_frame, '0, 1'b0, 1'b0);
            rsp_valid <= 1'b1;
            inv_done  <= 1'b1;
            state     <= S_IDLE;
          end else begin
            ev_valid <= 1'b1;
            ev_pid   <= r_pid[cs];
            ev_vpn   <= r_vpn[cs];
            cur      <= r_fnext[cs];
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rsp_err   = rsp_q.err;
  assign rsp_hit   = rsp_q.hit;
  assign rsp_frame = rsp_q.frame;
  assign rsp_count = rsp_q.cnt;
  assign rsp_lock  = rsp_q.lock;
  assign rsp_dirty = rsp_q.dirty;

  // R7
  ev_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !cmd_ready);
  // R7
  ev_rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && rsp_valid));
  // R7
  done_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> rsp_valid);
  // R3
  map_full_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && q_op == OP_MAP && pool_empty) |=> (rsp_valid && rsp_err));
  // R8
  locked_inval_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && c_op == OP_INVAL && tb.lock) |=> (rsp_valid && rsp_err && !ev_valid));
  // R6
  free_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> rsp_valid);
endmodule

// File: tb/test_frame_alias_tracker.sv
`timescale 1ns/1ps
module test_frame_alias_tracker;
  localparam int OP_MAP = 0, OP_UNMAP = 1, OP_LOOKUP = 2, OP_INVAL = 3;
  localparam int OP_LOCK = 4, OP_UNLOCK = 5, OP_MOVE = 6, OP_QUERY = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_dirty = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_pid = '0;
  logic [19:0] cmd_vpn = '0;
  logic [4:0] cmd_frame = '0;
  logic rsp_valid, rsp_err, rsp_hit, rsp_lock, rsp_dirty;
  logic [4:0] rsp_frame;
  logic [6:0] rsp_count;
  logic ev_valid, inv_done, free_valid;
  logic [7:0] ev_pid;
  logic [19:0] ev_vpn;
  logic [4:0] free_frame;

  frame_alias_tracker i_frame_alias_tracker (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_pid, .cmd_vpn, .cmd_frame,
    .cmd_dirty, .rsp_valid, .rsp_err, .rsp_hit, .rsp_frame, .rsp_count, .rsp_lock,
    .rsp_dirty, .ev_valid, .ev_pid, .ev_vpn, .inv_done, .free_valid, .free_frame);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, live = 0;
  int r_err, r_hit, r_frame, r_cnt, r_lock, r_dirty, r_free, r_free_id, r_done, r_cyc;
  int n_ev;
  int ev_p[64], ev_v[64], ev_c[64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got cycle %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fold(input int pid, input int vpn);
    longint k;
    int b;
    k = (longint'(pid) << 20) | longint'(vpn);
    b = 0;
    for (int s = 0; s < 28; s += 4) b = b ^ int'((k >> s) & 15);
    return b;
  endfunction

  task automatic cmd(input int op, input int pid, input int vpn, input int fr, input int dty);
    int guard;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pid = 8'(pid); cmd_vpn = 20'(vpn);
    cmd_frame = 5'(fr); cmd_dirty = dty[0];
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n_ev = 0; guard = 0;
    while (!rsp_valid && guard < 500) begin
      if (ev_valid && n_ev < 64) begin
        ev_p[n_ev] = int'(ev_pid); ev_v[n_ev] = int'(ev_vpn); ev_c[n_ev] = cyc; n_ev++;
      end
      @(negedge clk);
      guard++;
    end
    if (!rsp_valid) chk("R1", "response timeout", 0, 1);
    r_err = int'(rsp_err); r_hit = int'(rsp_hit); r_frame = int'(rsp_frame);
    r_cnt = int'(rsp_count); r_lock = int'(rsp_lock); r_dirty = int'(rsp_dirty);
    r_free = int'(free_valid); r_free_id = int'(free_frame); r_done = int'(inv_done);
    r_cyc = cyc;
  endtask

  task automatic map_ok(input string req, input int pid, input int vpn, input int fr, input int dty);
    cmd(OP_MAP, pid, vpn, fr, dty);
    chk(req, "map accepted", r_err, 0);
    live++;
  endtask

  task automatic unmap_ok(input string req, input int pid, input int vpn);
    cmd(OP_UNMAP, pid, vpn, 0, 0);
    chk(req, "unmap accepted", r_err, 0);
    live--;
  endtask

  task automatic query(input string req, input int fr, input int cnt, input int lk, input int dty);
    cmd(OP_QUERY, 0, 0, fr, 0);
    chk(req, "query count", r_cnt, cnt);
    chk(req, "query lock", r_lock, lk);
    chk(req, "query dirty", r_dirty, dty);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "cmd_ready", int'(cmd_ready), 1);
    chk("R1", "rsp_valid idle", int'(rsp_valid), 0);
    chk("R1", "ev_valid idle", int'(ev_valid), 0);
    chk("R1", "free_valid idle", int'(free_valid), 0);
    query("R1", 5, 0, 0, 0);
    cmd(OP_LOOKUP, 1, 'h100, 0, 0);
    chk("R1", "lookup miss", r_hit, 0);
  endtask

  task automatic t_map_share;
    map_ok("R2", 1, 'h100, 3, 0);
    map_ok("R2", 2, 'h200, 3, 1);
    map_ok("R2", 3, 'h300, 3, 0);
    query("R2", 3, 3, 0, 1);
    cmd(OP_LOOKUP, 2, 'h200, 0, 0);
    chk("R4", "lookup hit", r_hit, 1);
    chk("R4", "lookup frame", r_frame, 3);
    chk("R4", "lookup count", r_cnt, 3);
    cmd(OP_INVAL, 0, 0, 3, 0);
    chk("R7", "event count", n_ev, 3);
    chk("R7", "first event pid", ev_p[0], 3);
    chk("R7", "second event vpn", ev_v[1], 'h200);
    chk("R7", "third event pid", ev_p[2], 1);
    chk("R7", "events back to back", ev_c[2] - ev_c[0], 2);
    chk("R7", "done right after last event", r_cyc - ev_c[2], 1);
    chk("R7", "inv_done", r_done, 1);
    query("R7", 3, 3, 0, 1);
    cmd(OP_MAP, 1, 'h100, 4, 0);
    chk("R3", "duplicate map err", r_err, 1);
    chk("R3", "duplicate map hit", r_hit, 1);
    query("R3", 4, 0, 0, 0);
    cmd(OP_INVAL, 0, 0, 9, 0);
    chk("R7", "empty frame events", n_ev, 0);
    chk("R7", "empty frame done", r_done, 1);
  endtask

  task automatic t_unmap_free;
    unmap_ok("R5", 2, 'h200);
    chk("R5", "no free while sharers remain", r_free, 0);
    query("R5", 3, 2, 0, 1);
    cmd(OP_INVAL, 0, 0, 3, 0);
    chk("R5", "events after middle unmap", n_ev, 2);
    chk("R5", "head sharer", ev_p[0], 3);
    chk("R5", "tail sharer", ev_p[1], 1);
    unmap_ok("R5", 3, 'h300);
    unmap_ok("R6", 1, 'h100);
    chk("R6", "free pulse", r_free, 1);
    chk("R6", "free frame id", r_free_id, 3);
    query("R6", 3, 0, 0, 0);
    cmd(OP_UNMAP, 1, 'h100, 0, 0);
    chk("R5", "unknown key unmap err", r_err, 1);
  endtask

  task automatic t_collide;
    int a, b, c;
    a = 'h00345; b = a ^ 'h11; c = a ^ 'h22;
    chk("R4", "bench keys collide", fold('h21, b), fold('h21, a));
    chk("R4", "bench keys collide 2", fold('h21, c), fold('h21, a));
    map_ok("R4", 'h21, a, 7, 0);
    map_ok("R4", 'h21, b, 8, 0);
    map_ok("R4", 'h21, c, 9, 0);
    cmd(OP_LOOKUP, 'h21, a, 0, 0);
    chk("R4", "chain tail frame", r_frame, 7);
    cmd(OP_LOOKUP, 'h21, b, 0, 0);
    chk("R4", "chain middle frame", r_frame, 8);
    cmd(OP_LOOKUP, 'h21, c, 0, 0);
    chk("R4", "chain head frame", r_frame, 9);
    unmap_ok("R5", 'h21, b);
    cmd(OP_LOOKUP, 'h21, b, 0, 0);
    chk("R5", "removed key misses", r_hit, 0);
    cmd(OP_LOOKUP, 'h21, a, 0, 0);
    chk("R5", "tail still found", r_frame, 7);
    cmd(OP_LOOKUP, 'h21, c, 0, 0);
    chk("R5", "head still found", r_frame, 9);
  endtask

  task automatic t_lock;
    map_ok("R8", 9, 'h900, 10, 0);
    cmd(OP_LOCK, 0, 0, 10, 0);
    chk("R8", "lock accepted", r_err, 0);
    cmd(OP_MAP, 9, 'h901, 10, 0);
    chk("R8", "map into locked err", r_err, 1);
    cmd(OP_UNMAP, 9, 'h900, 0, 0);
    chk("R8", "unmap locked err", r_err, 1);
    cmd(OP_INVAL, 0, 0, 10, 0);
    chk("R8", "inval locked err", r_err, 1);
    chk("R8", "inval locked no events", n_ev, 0);
    cmd(OP_MOVE, 9, 'h900, 11, 0);
    chk("R8", "move from locked err", r_err, 1);
    cmd(OP_LOOKUP, 9, 'h900, 0, 0);
    chk("R8", "lookup served", r_hit, 1);
    chk("R8", "lookup sees lock", r_lock, 1);
    query("R8", 10, 1, 1, 0);
    cmd(OP_UNLOCK, 0, 0, 10, 0);
    map_ok("R8", 9, 'h901, 10, 0);
    query("R8", 10, 2, 0, 0);
  endtask

  task automatic t_move;
    map_ok("R9", 4, 'h40, 12, 0);
    map_ok("R9", 5, 'h50, 12, 0);
    map_ok("R9", 6, 'h60, 12, 0);
    cmd(OP_MOVE, 5, 'h50, 13, 0);
    chk("R9", "move accepted", r_err, 0);
    query("R9", 12, 2, 0, 0);
    query("R9", 13, 1, 0, 1);
    cmd(OP_LOOKUP, 5, 'h50, 0, 0);
    chk("R9", "moved alias frame", r_frame, 13);
    cmd(OP_INVAL, 0, 0, 12, 0);
    chk("R9", "remaining sharers", n_ev, 2);
    chk("R9", "sharer order head", ev_p[0], 6);
    chk("R9", "sharer order tail", ev_p[1], 4);
    cmd(OP_MOVE, 4, 'h40, 12, 0);
    chk("R9", "same frame move err", r_err, 1);
    cmd(OP_MOVE, 7, 'h70, 12, 0);
    chk("R9", "unknown key move err", r_err, 1);
    cmd(OP_LOCK, 0, 0, 14, 0);
    cmd(OP_MOVE, 5, 'h50, 14, 0);
    chk("R8", "move into locked err", r_err, 1);
    cmd(OP_UNLOCK, 0, 0, 14, 0);
    cmd(OP_MOVE, 5, 'h50, 14, 0);
    chk("R9", "second move accepted", r_err, 0);
    chk("R6", "free pulse on move", r_free, 1);
    chk("R6", "freed frame on move", r_free_id, 13);
    query("R6", 13, 0, 0, 0);
    query("R10", 14, 1, 0, 1);
  endtask

  task automatic t_exhaust;
    int start;
    start = live;
    for (int i = 0; i < 64 - start; i++) map_ok("R3", 'h80 + i, 'h1000 + i, 16 + (i % 8), 0);
    chk("R3", "bench slot count", live, 64);
    cmd(OP_MAP, 'hFE, 'hABC, 20, 0);
    chk("R3", "full map err", r_err, 1);
    chk("R3", "full map no hit", r_hit, 0);
    query("R3", 20, ((64 - start) + 3) / 8, 0, 0);
    unmap_ok("R3", 'h80, 'h1000);
    map_ok("R3", 'hFF, 'hFFF, 16, 0);
    cmd(OP_LOOKUP, 'hFF, 'hFFF, 0, 0);
    chk("R3", "reused slot lookup", r_frame, 16);
    query("R3", 16, ((64 - start) + 7) / 8, 0, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map_share();
    t_unmap_free();
    t_collide();
    t_lock();
    t_move();
    t_exhaust();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule